// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that executes a small 32-bit load/store instruction subset over several clock cycles. One ALU and one memory are shared by all steps of an instruction. The sequencer holds the current step in a state register and, as a Moore machine, drives every datapath control line from that step alone. The 6-bit opcode of the instruction register is read only when the next step is chosen.

Every instruction begins with a fetch step and then a decode step. The path after decode depends on the instruction class. Word loads take five cycles. Word stores and register-register arithmetic take four. Branch-if-equal and absolute jump take three. The last step of each path returns to fetch. An opcode outside the subset goes back to fetch straight after decode. The datapath and the ALU function decoder are separate blocks.

Top module: `mcyc_ctrl`

## Requirements
- R1: While rst_n is low the sequencer is in the fetch step, and its outputs show the fetch pattern as soon as reset is applied, without waiting for a clock.
- R2: Fetch step: mem_rd=1, ir_wr=1, pc_wr=1, addr_sel=0 (address from PC), srca_sel=0 (PC), srcb_sel=01 (constant 4), alu_op=00, pc_sel=00 (ALU result). All other outputs are 0. Decode always follows.
- R3: Decode step: srca_sel=0, srcb_sel=11 (immediate shifted left by two), alu_op=00. All other outputs are 0, so the speculative branch target is computed and nothing is written.
- R4: Load (opcode 6'h23) takes 5 cycles. Address step: srca_sel=1 (register A), srcb_sel=10 (immediate), alu_op=00. Read step: mem_rd=1, addr_sel=1. Write-back step: rf_wr=1, wb_sel=1 (memory data register), dst_sel=0 (rt field).
- R5: Store (opcode 6'h2B) takes 4 cycles. Its address step matches the load's. Then comes mem_wr=1 with addr_sel=1, and after that fetch.
- R6: Register arithmetic (opcode 6'h00) takes 4 cycles. Execute step: srca_sel=1, srcb_sel=00 (register B), alu_op=10 (function-field lookup). Write-back step: rf_wr=1, wb_sel=0, dst_sel=1 (rd field).
- R7: Branch-if-equal (opcode 6'h04) takes 3 cycles. Its last step has srca_sel=1, srcb_sel=00, alu_op=01 (subtract), pc_wr_cond=1, pc_sel=01 (ALU output register), and pc_wr=0.
- R8: Jump (opcode 6'h02) takes 3 cycles. Its last step has pc_wr=1 and pc_sel=10 (jump target), with every other output 0.
- R9: Any other opcode leaves decode for fetch, so that instruction takes 2 cycles and writes nothing.
- R10: mem_rd and mem_wr are never high together, and rf_wr is never high together with mem_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU reports equality |
| ir_wr | output | 1 | Instruction register write |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| wb_sel | output | 1 | Register write data: 0 ALU output register, 1 memory data register |
| dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| rf_wr | output | 1 | Register file write |
| srca_sel | output | 1 | ALU input A: 0 PC, 1 register A |
| srcb_sel | output | 2 | ALU input B: 00 B, 01 four, 10 immediate, 11 immediate<<2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function lookup |
| pc_sel | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target |

## Verification
The bench uses the default opcode parameters (6'h23, 6'h2B, 6'h00, 6'h04, 6'h02). Each of the five instruction paths and the fallback path for an unlisted opcode can therefore be driven with its real code. The bench runs the paths back to back in more than one order, so each path is shown to hand over cleanly to the next fetch. An asynchronous reset is also applied partway through a load, which shows that the block returns to fetch immediately.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_MADDR,
    ST_MREAD,
    ST_MLOADWB,
    ST_MSTORE,
    ST_EXEC,
    ST_ALUWB,
    ST_BRANCH,
    ST_JUMP
  } step_e;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNC  = 2'b10;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMMS = 2'b11;

  localparam logic [1:0] PCSEL_ALU = 2'b00;
  localparam logic [1:0] PCSEL_OUT = 2'b01;
  localparam logic [1:0] PCSEL_JMP = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       wb_sel;
    logic       dst_sel;
    logic       rf_wr;
    logic       srca_sel;
    logic [1:0] srcb_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_sel;
  } ctrl_t;

endpackage

// File: rtl/mcyc_step_reg.sv
module mcyc_step_reg
  import mcyc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_e step_nxt,
  output step_e step_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
    end else begin
      step_q <= step_nxt;
    end
  end

endmodule

// File: rtl/mcyc_step_next.sv
module mcyc_step_next
  import mcyc_pkg::*;
#(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_LOAD  = 6'h23,
  parameter logic [OPW-1:0]  OP_STORE = 6'h2B,
  parameter logic [OPW-1:0]  OP_ARITH = 6'h00,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_JUMP  = 6'h02
) (
  input  step_e          step_q,
  input  logic [OPW-1:0] opcode,
  output step_e          step_nxt
);

  logic is_mem;
  assign is_mem = (opcode == OP_LOAD) || (opcode == OP_STORE);

  always_comb begin
    step_nxt = ST_FETCH;
    unique case (step_q)
      ST_FETCH:  step_nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_mem)                  step_nxt = ST_MADDR;
        else if (opcode == OP_ARITH) step_nxt = ST_EXEC;
        else if (opcode == OP_BEQ)   step_nxt = ST_BRANCH;
        else if (opcode == OP_JUMP)  step_nxt = ST_JUMP;
        else                         step_nxt = ST_FETCH;
      end
      ST_MADDR:  step_nxt = (opcode == OP_LOAD) ? ST_MREAD : ST_MSTORE;
      ST_MREAD:  step_nxt = ST_MLOADWB;
      ST_EXEC:   step_nxt = ST_ALUWB;
      default:   step_nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_decode.sv
module mcyc_ctrl_decode
  import mcyc_pkg::*;
(
  input  step_e step_q,
  output ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (step_q)
      ST_FETCH: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.ir_wr    = 1'b1;
        ctrl.pc_wr    = 1'b1;
        ctrl.srcb_sel = SRCB_FOUR;
        ctrl.alu_op   = ALU_ADD;
        ctrl.pc_sel   = PCSEL_ALU;
      end
      ST_DECODE: begin
        ctrl.srcb_sel = SRCB_IMMS;
        ctrl.alu_op   = ALU_ADD;
      end
      ST_MADDR: begin
        ctrl.srca_sel = 1'b1;
        ctrl.srcb_sel = SRCB_IMM;
        ctrl.alu_op   = ALU_ADD;
      end
      ST_MREAD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_MLOADWB: begin
        ctrl.rf_wr    = 1'b1;
        ctrl.wb_sel   = 1'b1;
      end
      ST_MSTORE: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.srca_sel = 1'b1;
        ctrl.srcb_sel = SRCB_REG;
        ctrl.alu_op   = ALU_FUNC;
      end
      ST_ALUWB: begin
        ctrl.rf_wr    = 1'b1;
        ctrl.dst_sel  = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.srca_sel   = 1'b1;
        ctrl.srcb_sel   = SRCB_REG;
        ctrl.alu_op     = ALU_SUB;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_sel     = PCSEL_OUT;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_sel = PCSEL_JMP;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_LOAD  = 6'h23,
  parameter logic [OPW-1:0]  OP_STORE = 6'h2B,
  parameter logic [OPW-1:0]  OP_ARITH = 6'h00,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_JUMP  = 6'h02
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           ir_wr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           addr_sel,
  output logic           wb_sel,
  output logic           dst_sel,
  output logic           rf_wr,
  output logic           srca_sel,
  output logic [1:0]     srcb_sel,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_sel
);

  step_e step_q;
  step_e step_nxt;
  ctrl_t ctrl;

  mcyc_step_next #(
    .OPW(OPW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_ARITH(OP_ARITH), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
  ) i_next (
    .step_q  (step_q),
    .opcode  (opcode),
    .step_nxt(step_nxt)
  );

  mcyc_step_reg i_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_nxt(step_nxt),
    .step_q  (step_q)
  );

  mcyc_ctrl_decode i_dec (
    .step_q(step_q),
    .ctrl  (ctrl)
  );

  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign ir_wr      = ctrl.ir_wr;
  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign addr_sel   = ctrl.addr_sel;
  assign wb_sel     = ctrl.wb_sel;
  assign dst_sel    = ctrl.dst_sel;
  assign rf_wr      = ctrl.rf_wr;
  assign srca_sel   = ctrl.srca_sel;
  assign srcb_sel   = ctrl.srcb_sel;
  assign alu_op     = ctrl.alu_op;
  assign pc_sel     = ctrl.pc_sel;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk #(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_LOAD  = 6'h23,
  parameter logic [OPW-1:0]  OP_STORE = 6'h2B,
  parameter logic [OPW-1:0]  OP_ARITH = 6'h00,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_JUMP  = 6'h02
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] opcode,
  input logic           pc_wr,
  input logic           pc_wr_cond,
  input logic           ir_wr,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           addr_sel,
  input logic           wb_sel,
  input logic           dst_sel,
  input logic           rf_wr,
  input logic           srca_sel,
  input logic [1:0]     srcb_sel,
  input logic [1:0]     alu_op,
  input logic [1:0]     pc_sel
);

  logic op_known;
  assign op_known = (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                    (opcode == OP_ARITH) || (opcode == OP_BEQ) ||
                    (opcode == OP_JUMP);

  p_fetch_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> (pc_wr && mem_rd && !addr_sel && !srca_sel && srcb_sel == 2'b01));

  p_decode_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (!ir_wr && srcb_sel == 2'b11 && !rf_wr && !mem_wr));

  p_load_wb_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && wb_sel) |-> (!dst_sel && $past(mem_rd && addr_sel)));

  p_store_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr);

  p_arith_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && dst_sel) |-> $past(alu_op == 2'b10));

  p_branch_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |-> (alu_op == 2'b01 && pc_sel == 2'b01 && !pc_wr));

  p_jump_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_sel == 2'b10) |=> ir_wr);

  p_unknown_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (srcb_sel == 2'b11 && !op_known) |=> ir_wr);

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && (mem_rd || rf_wr)));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk #(
  .OPW(OPW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
  .OP_ARITH(OP_ARITH), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
) i_chk (.*);

// File: tb/test_mcyc_ctrl.sv
module test_mcyc_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_wr, pc_wr_cond, ir_wr, mem_rd, mem_wr, addr_sel;
  logic       wb_sel, dst_sel, rf_wr, srca_sel;
  logic [1:0] srcb_sel, alu_op, pc_sel;

  int n_chk;
  int n_fail;
  bit mon_en;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  mcyc_ctrl i_mcyc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
    .wb_sel(wb_sel), .dst_sel(dst_sel), .rf_wr(rf_wr),
    .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op),
    .pc_sel(pc_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Field order: pc_wr pc_wr_cond ir_wr mem_rd mem_wr addr_sel wb_sel
  //              dst_sel rf_wr srca_sel srcb_sel[2] alu_op[2] pc_sel[2]
  localparam logic [15:0] V_FETCH  = {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
  localparam logic [15:0] V_DECODE = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00};
  localparam logic [15:0] V_MADDR  = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,2'b00};
  localparam logic [15:0] V_MREAD  = {1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00};
  localparam logic [15:0] V_LDWB   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,2'b00};
  localparam logic [15:0] V_STORE  = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00};
  localparam logic [15:0] V_EXEC   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00};
  localparam logic [15:0] V_ALUWB  = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,2'b00};
  localparam logic [15:0] V_BRANCH = {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,2'b01};
  localparam logic [15:0] V_JUMP   = {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10};

  function automatic logic [15:0] outs();
    return {pc_wr, pc_wr_cond, ir_wr, mem_rd, mem_wr, addr_sel, wb_sel,
            dst_sel, rf_wr, srca_sel, srcb_sel, alu_op, pc_sel};
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic push(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Driver: called just after a rising edge, with the block about to show fetch.
  task automatic run_instr(input logic [5:0] op);
    int n;
    opcode = op;
    push(V_FETCH, "R2 fetch");
    push(V_DECODE, "R3 decode");
    n = 2;
    case (op)
      6'h23: begin
        push(V_MADDR, "R4 load address"); push(V_MREAD, "R4 load read");
        push(V_LDWB, "R4 load write-back"); n = 5;
      end
      6'h2B: begin
        push(V_MADDR, "R5 store address"); push(V_STORE, "R5 store write");
        n = 4;
      end
      6'h00: begin
        push(V_EXEC, "R6 execute"); push(V_ALUWB, "R6 write-back"); n = 4;
      end
      6'h04: begin push(V_BRANCH, "R7 branch"); n = 3; end
      6'h02: begin push(V_JUMP, "R8 jump"); n = 3; end
      default: n = 2;  // R9 unlisted opcode
    endcase
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pops one expected item per cycle, on the falling edge.
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [15:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(outs(), e, t);
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    mon_en = 1'b0;
    opcode = 6'h00;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check(outs(), V_FETCH, "R1 fetch held in reset");
    @(posedge clk); #1;
    rst_n  = 1'b1;
    mon_en = 1'b1;

    run_instr(6'h23);
    run_instr(6'h2B);
    run_instr(6'h00);
    run_instr(6'h04);
    run_instr(6'h02);
    run_instr(6'h3F);
    run_instr(6'h02);
    run_instr(6'h23);
    run_instr(6'h11);
    run_instr(6'h04);
    run_instr(6'h00);
    run_instr(6'h2B);
    run_instr(6'h23);

    // R1: asynchronous reset in the middle of a load
    mon_en = 1'b0;
    opcode = 6'h23;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check(outs(), V_MADDR, "R4 address step before reset");
    rst_n = 1'b0;
    #1;
    check(outs(), V_FETCH, "R1 async reset to fetch");
    @(posedge clk); #1;
    check(outs(), V_FETCH, "R1 fetch held across edge");
    rst_n  = 1'b1;
    mon_en = 1'b1;
    run_instr(6'h00);
    run_instr(6'h2B);

    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule